// File: doc/BRIEF.md
# Vectored Interrupt Controller with Per-Source Masks

This block gathers interrupt requests for a small 32-bit processor core and presents one of them at a time as a vector number together with the address of that vector's slot in a handler-pointer table held at a fixed base address. Vectors 0 to 5 carry synchronous exceptions: divide by zero, hardware error, arithmetic overflow, illegal opcode, protection fault and translation miss. Vector 6 is the operating system's software trap. Vectors 7 to 31 belong to platform devices.

A pending source can be taken only when the global enable is set and the source's own mask bit is set. The hardware-error vector is the exception: it is taken whatever the state of the enable and its mask bit. The lowest-numbered eligible vector wins. The controller holds its request until the core returns a one-cycle acknowledge. On that acknowledge it clears the global enable, the mask bit of the accepted vector and that vector's pending bit. Software must then set the enable again and write the mask bit back.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After a synchronous reset, `req_valid`, `ie_out` and every bit of `mask_out` are 0, and no pending source is held.
- R2: A one-cycle high on `exc_pulse[i]` (i in 0..6) latches pending vector i. A high level on `plat_lvl[j]` latches pending vector j+7. A source driven before clock edge A shows up on the request outputs after the following edge B, when it is eligible and no request is outstanding.
- R3: Among eligible pending vectors, the one with the lowest number is presented on `req_vec`.
- R4: Every vector except 1 is eligible only while `ie_out` is 1 and its bit in `mask_out` is 1. Otherwise it raises no request and stays pending.
- R5: Vector 1 is eligible whenever it is pending, even with `ie_out` at 0 and mask bit 1 at 0.
- R6: While `req_valid` is 1, `req_addr` equals `TABLE_BASE + req_vec`.
- R7: While `req_valid` is 1 and `ack` is 0, `req_valid`, `req_vec` and `req_addr` stay unchanged, even if a lower-numbered vector becomes pending.
- R8: An edge with `req_valid` and `ack` both 1 drops `req_valid`, clears `ie_out` and clears the accepted vector's mask bit and pending bit. The other mask bits and the other pending bits are left as they were.
- R9: `ack` while `req_valid` is 0 has no effect on `ie_out`, `mask_out` or `req_valid`.
- R10: `ie_set` sets the global enable and `ie_clr` clears it at the next edge. If both are high, clear wins. An acceptance in the same cycle forces the enable to 0.
- R11: `mask_wr` loads `mask_wdata` into `mask_out` at the next edge.
- R12: A platform level that is still high in the cycle after its acceptance is latched pending again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_pulse | input | 7 | Single-cycle exception and trap strobes, vectors 0..6 |
| plat_lvl | input | 25 | Level-sensitive device lines, vectors 7..31 |
| ie_set | input | 1 | Set the global interrupt enable |
| ie_clr | input | 1 | Clear the global interrupt enable |
| mask_wr | input | 1 | Write strobe for the mask register |
| mask_wdata | input | 32 | New mask value, bit n enables vector n |
| ack | input | 1 | Core accepts the presented vector |
| req_valid | output | 1 | A vector is being presented |
| req_vec | output | 5 | Presented vector number |
| req_addr | output | 32 | Address of the handler-pointer slot for the vector |
| ie_out | output | 1 | Current global enable |
| mask_out | output | 32 | Current mask register |

## Verification
A table of stimulus patterns drives single exceptions, pairs of exceptions, pairs that mix exceptions with device lines, a lower source that is masked, a closed global enable, a hardware error with everything masked, the top vector alone, and a masked vector 0 competing with the hardware error. Taken together these separate lowest-first priority from mask gating and from the enable gate, and they show the bypass for vector 1. After each acceptance the bench opens the enable again and sets every mask bit. This shows that only the accepted pending bit was dropped and that the next-lowest source follows. Directed cases cover a request that stays frozen while a lower vector arrives, acknowledges with no request outstanding, set and clear of the enable in the same cycle, and a device line that stays high across its acceptance.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int VEC_COUNT   = 32;
  localparam int SYNC_COUNT  = 7;
  localparam int HW_ERR_VEC  = 1;
  localparam int PTR_WIDTH   = 32;
  localparam logic [PTR_WIDTH-1:0] TBL_BASE_DEF = 32'h0000_0100;
endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int NUM_VEC = 32,
  parameter int EXC_NUM = 7,
  localparam int VEC_W  = $clog2(NUM_VEC),
  localparam int PLAT_N = NUM_VEC - EXC_NUM
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [EXC_NUM-1:0] exc_pulse,
  input  logic [PLAT_N-1:0]  plat_lvl,
  input  logic               clr_en,
  input  logic [VEC_W-1:0]   clr_idx,
  output logic [NUM_VEC-1:0] pend
);
  logic [NUM_VEC-1:0] raw;
  assign raw = {plat_lvl, exc_pulse};

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_bit
    logic hit;
    assign hit = clr_en && (clr_idx == VEC_W'(g));
    always_ff @(posedge clk) begin
      if (rst)      pend[g] <= 1'b0;
      else if (hit) pend[g] <= 1'b0;
      else if (raw[g]) pend[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N      = 32,
  localparam int VEC_W = $clog2(N)
) (
  input  logic [N-1:0]     cand,
  output logic             found,
  output logic [VEC_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = VEC_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NUM_VEC = irq_pkg::VEC_COUNT,
  parameter int EXC_NUM = irq_pkg::SYNC_COUNT,
  parameter int NMI_VEC = irq_pkg::HW_ERR_VEC,
  parameter int ADDR_W  = irq_pkg::PTR_WIDTH,
  parameter logic [ADDR_W-1:0] TABLE_BASE = irq_pkg::TBL_BASE_DEF,
  localparam int VEC_W  = $clog2(NUM_VEC),
  localparam int PLAT_N = NUM_VEC - EXC_NUM
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [EXC_NUM-1:0] exc_pulse,
  input  logic [PLAT_N-1:0]  plat_lvl,
  input  logic               ie_set,
  input  logic               ie_clr,
  input  logic               mask_wr,
  input  logic [NUM_VEC-1:0] mask_wdata,
  input  logic               ack,
  output logic               req_valid,
  output logic [VEC_W-1:0]   req_vec,
  output logic [ADDR_W-1:0]  req_addr,
  output logic               ie_out,
  output logic [NUM_VEC-1:0] mask_out
);
  localparam logic [NUM_VEC-1:0] NMI_BIT = NUM_VEC'(1) << NMI_VEC;

  logic [NUM_VEC-1:0] pend, elig, mask_nxt;
  logic               accept, found;
  logic [VEC_W-1:0]   win;

  assign accept = req_valid && ack;

  irq_pending #(.NUM_VEC(NUM_VEC), .EXC_NUM(EXC_NUM)) u_pend (
    .clk(clk), .rst(rst), .exc_pulse(exc_pulse), .plat_lvl(plat_lvl),
    .clr_en(accept), .clr_idx(req_vec), .pend(pend)
  );

  assign elig = pend & ((mask_out & {NUM_VEC{ie_out}}) | NMI_BIT);

  irq_prio_pick #(.N(NUM_VEC)) u_pick (.cand(elig), .found(found), .idx(win));

  always_comb begin
    mask_nxt = mask_wr ? mask_wdata : mask_out;
    if (accept) mask_nxt[req_vec] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_vec   <= '0;
      req_addr  <= '0;
      ie_out    <= 1'b0;
      mask_out  <= '0;
    end else begin
      mask_out <= mask_nxt;
      if (accept)      ie_out <= 1'b0;
      else if (ie_clr) ie_out <= 1'b0;
      else if (ie_set) ie_out <= 1'b1;
      if (accept) begin
        req_valid <= 1'b0;
      end else if (!req_valid && found) begin
        req_valid <= 1'b1;
        req_vec   <= win;
        req_addr  <= TABLE_BASE + ADDR_W'(win);
      end
    end
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int NUM_VEC = 32,
  parameter int NMI_VEC = 1,
  parameter int ADDR_W  = 32,
  parameter logic [ADDR_W-1:0] TABLE_BASE = '0,
  localparam int VEC_W  = $clog2(NUM_VEC)
) (
  input logic               clk,
  input logic               rst,
  input logic               ack,
  input logic               req_valid,
  input logic [VEC_W-1:0]   req_vec,
  input logic [ADDR_W-1:0]  req_addr,
  input logic               ie_out,
  input logic [NUM_VEC-1:0] mask_out
);
  logic               prev_ie;
  logic [NUM_VEC-1:0] prev_mask;
  logic [VEC_W-1:0]   took_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_ie   <= 1'b0;
      prev_mask <= '0;
      took_vec  <= '0;
    end else begin
      prev_ie   <= ie_out;
      prev_mask <= mask_out;
      took_vec  <= req_vec;
    end
  end

  a_r8_ack_drops_enable: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ack) |=> (!ie_out && !req_valid));

  a_r8_ack_clears_mask_bit: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ack) |=> !mask_out[took_vec]);

  a_r7_request_frozen: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !ack) |=> (req_valid && $stable(req_vec) && $stable(req_addr)));

  a_r6_slot_address: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_addr == TABLE_BASE + ADDR_W'(req_vec)));

  a_r4_gated_unless_nmi: assert property (@(posedge clk) disable iff (rst)
    $rose(req_valid) |-> ((req_vec == VEC_W'(NMI_VEC)) || (prev_ie && prev_mask[req_vec])));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
  .NUM_VEC(NUM_VEC), .NMI_VEC(NMI_VEC), .ADDR_W(ADDR_W), .TABLE_BASE(TABLE_BASE)
) u_chk (
  .clk(clk), .rst(rst), .ack(ack), .req_valid(req_valid), .req_vec(req_vec),
  .req_addr(req_addr), .ie_out(ie_out), .mask_out(mask_out)
);

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0000_0100;
  localparam int NT = 9;
  // entry: [70:39] sources, [38:7] mask, [6] ie, [5] expect request, [4:0] expected vector
  localparam logic [70:0] TBL [NT] = '{
    {32'h0000_0001, 32'hFFFF_FFFF, 1'b1, 1'b1, 5'd0},
    {32'h0000_0024, 32'hFFFF_FFFF, 1'b1, 1'b1, 5'd2},
    {32'h0010_0080, 32'hFFFF_FFFF, 1'b1, 1'b1, 5'd7},
    {32'h0010_0080, 32'hFFFF_FF7F, 1'b1, 1'b1, 5'd20},
    {32'h0000_0008, 32'hFFFF_FFFF, 1'b0, 1'b0, 5'd0},
    {32'h0000_0002, 32'h0000_0000, 1'b0, 1'b1, 5'd1},
    {32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b1, 5'd31},
    {32'h0000_0003, 32'hFFFF_FFFE, 1'b1, 1'b1, 5'd1},
    {32'h0000_0400, 32'h0000_0000, 1'b1, 1'b0, 5'd0}
  };

  logic        clk = 0, rst = 1;
  logic [6:0]  exc_pulse = '0;
  logic [24:0] plat_lvl = '0;
  logic        ie_set = 0, ie_clr = 0, mask_wr = 0, ack = 0;
  logic [31:0] mask_wdata = '0;
  logic        req_valid, ie_out;
  logic [4:0]  req_vec;
  logic [31:0] req_addr, mask_out;
  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rst(rst), .exc_pulse(exc_pulse), .plat_lvl(plat_lvl),
    .ie_set(ie_set), .ie_clr(ie_clr), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .ack(ack), .req_valid(req_valid), .req_vec(req_vec), .req_addr(req_addr),
    .ie_out(ie_out), .mask_out(mask_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic do_reset();
    rst = 1; exc_pulse = '0; plat_lvl = '0; ie_set = 0; ie_clr = 0;
    mask_wr = 0; ack = 0; mask_wdata = '0;
    step(); step();
    rst = 0;
  endtask

  task automatic arm(input logic [31:0] m, input logic ie);
    mask_wr = 1; mask_wdata = m; ie_set = ie;
    step();
    mask_wr = 0; ie_set = 0;
  endtask

  task automatic pulse_src(input logic [31:0] s);
    exc_pulse = s[6:0]; plat_lvl = s[31:7];
    step();
    exc_pulse = '0; plat_lvl = '0;
    step();
  endtask

  task automatic do_ack();
    ack = 1; step(); ack = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 req_valid", 32'(req_valid), 0);
    check("R1 ie_out", 32'(ie_out), 0);
    check("R1 mask_out", mask_out, 0);

    for (int e = 0; e < NT; e++) begin
      logic [31:0] src, msk, rem;
      logic ie_v, exp_v;
      logic [4:0] exp_vec;
      int low;
      {src, msk, ie_v, exp_v, exp_vec} = TBL[e];
      do_reset();
      arm(msk, ie_v);
      pulse_src(src);
      // R2 R3 R4 R5 presence and choice
      check("R2 R4 R5 req_valid", 32'(req_valid), 32'(exp_v));
      if (exp_v) begin
        check("R3 req_vec", 32'(req_vec), 32'(exp_vec));
        check("R6 req_addr", req_addr, BASE + 32'(exp_vec));
        do_ack();
        check("R8 req_valid after ack", 32'(req_valid), 0);
        check("R8 ie after ack", 32'(ie_out), 0);
        check("R8 mask after ack", mask_out, msk & ~(32'd1 << exp_vec));
        rem = src & ~(32'd1 << exp_vec);
        low = -1;
        for (int b = 31; b >= 0; b--) if (rem[b]) low = b;
        arm(32'hFFFF_FFFF, 1'b1);
        step();
        check("R8 other pending kept", 32'(req_valid), 32'(low >= 0));
        if (low >= 0) check("R8 next vector", 32'(req_vec), 32'(low));
      end
    end

    // R11 mask write
    do_reset();
    mask_wr = 1; mask_wdata = 32'hA5A5_0F0F; step(); mask_wr = 0;
    check("R11 mask load", mask_out, 32'hA5A5_0F0F);

    // R9 ack with nothing outstanding
    do_reset();
    arm(32'hFFFF_FFFF, 1'b1);
    do_ack(); step();
    check("R9 ie kept", 32'(ie_out), 1);
    check("R9 mask kept", mask_out, 32'hFFFF_FFFF);
    check("R9 no request", 32'(req_valid), 0);

    // R10 set/clear collision
    ie_set = 1; ie_clr = 1; step(); ie_set = 0; ie_clr = 0;
    check("R10 clear wins from 1", 32'(ie_out), 0);
    ie_set = 1; ie_clr = 1; step(); ie_set = 0; ie_clr = 0;
    check("R10 clear wins from 0", 32'(ie_out), 0);
    ie_set = 1; step(); ie_set = 0;
    check("R10 set alone", 32'(ie_out), 1);

    // R7 frozen request, then R10 acceptance beats set
    do_reset();
    arm(32'hFFFF_FFFF, 1'b1);
    pulse_src(32'h0010_0000);
    check("R7 first vec", 32'(req_vec), 20);
    exc_pulse = 7'h01; step(); exc_pulse = '0;
    step(); step();
    check("R7 still valid", 32'(req_valid), 1);
    check("R7 vec held", 32'(req_vec), 20);
    check("R7 addr held", req_addr, BASE + 32'd20);
    ack = 1; ie_set = 1; step(); ack = 0; ie_set = 0;
    check("R10 ack beats set", 32'(ie_out), 0);
    step();
    check("R4 gated while ie low", 32'(req_valid), 0);
    ie_set = 1; step(); ie_set = 0; step();
    check("R7 deferred vec0", 32'(req_vec), 0);
    check("R7 deferred valid", 32'(req_valid), 1);

    // R12 level held across acceptance
    do_reset();
    arm(32'hFFFF_FFFF, 1'b1);
    plat_lvl = 25'd1 << 2;  // vector 9
    step(); step();
    check("R12 first vec9", 32'(req_vec), 9);
    do_ack();
    step();
    plat_lvl = '0;
    arm(32'hFFFF_FFFF, 1'b1);
    step();
    check("R12 relatched valid", 32'(req_valid), 1);
    check("R12 relatched vec", 32'(req_vec), 9);
    do_ack();
    arm(32'hFFFF_FFFF, 1'b1);
    step();
    check("R12 dropped level not relatched", 32'(req_valid), 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule